// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Sequencer

This block runs one programmed-I/O transfer at a time on a parallel ATA channel that carries two drives. The host side presents a request: which drive is addressed, read or write, a three-bit register address, whether the access is a command-block cycle or a data-port cycle, and the write data. The sequencer then drives the address and the chip select, pulses the read or write strobe, and releases everything after a hold interval. For reads it returns the captured data.

The three phase lengths (address setup, strobe active, recovery) are taken from timing words given as inputs. Data cycles always use the addressed drive's data word. Command cycles use either one shared word that holds the slowest mode on the channel, or a command word kept for each drive, chosen by a format input. This lets a fast and a slow device share one channel. The device ready line is synchronized and sampled once, at a fixed point in the strobe phase. If it is low there, the strobe is stretched. A separate drive-reset output follows a software control bit and is never touched by the block reset.

Top module: `ide_pio_seq`

## Requirements
- R1: A transfer runs in three phases: setup, then strobe active, then recovery. `ide_cs_n` is low and `ide_addr` is stable through all three phases. A strobe is low only in the active phase, and never both strobes at once. `ide_dior_n` is used for reads and `ide_diow_n` for writes.
- R2: A timing word is packed as setup in bits [CNT_W-1:0], active in bits [2*CNT_W-1:CNT_W] and recovery in bits [3*CNT_W-1:2*CNT_W]. Each field gives a phase length in clocks. A field of 0 gives a phase of 1 clock.
- R3: A data cycle (`req_cmd`=0) takes its timing from slot `req_drive` of `dat_tim_drv` (slot n is bits [n*3*CNT_W +: 3*CNT_W]).
- R4: A command cycle (`req_cmd`=1) uses `cmd_tim_shared` when `fmt_sel`=0. It uses slot `req_drive` of `cmd_tim_drv` when `fmt_sel`=1.
- R5: `ide_iordy` passes through a two-flop synchronizer. Its synchronized value is sampled once per strobe, at the clock SAMPLE_PT clocks after strobe assertion, or at the last nominal active clock if that comes earlier. If it is high there, the strobe keeps its nominal length.
- R6: If the sampled ready is low, the strobe stays asserted past its nominal length. It is released at the end of the first clock, at or after the nominal end, in which the synchronized ready is high.
- R7: A low ready that reaches the synchronizer output only after the sample point does not lengthen the strobe.
- R8: A read captures `ide_dd_in` on the edge that releases `ide_dior_n`, and `rdata` holds that value afterwards. During a write, `ide_dd_oe` is high and `ide_dd_out` equals the request data from setup through recovery. `ide_dd_oe` is low otherwise.
- R9: `busy` is high from the clock after acceptance to the end of recovery. `done` is a single-clock pulse in the first idle clock after recovery.
- R10: A request is taken only when `busy` is low. `req_valid` during a transfer neither starts a new transfer nor changes the running one.
- R11: `ide_rst_n` equals the inverse of `rst_ctl` one clock later, whether or not `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| req_valid | input | 1 | Transfer request |
| req_drive | input | DRV_W | Addressed drive |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 1 | 1 = command-block cycle, 0 = data cycle |
| req_addr | input | ADDR_W | Device register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-transfer pulse |
| rdata | output | DATA_W | Last read data |
| fmt_sel | input | 1 | Command timing format |
| cmd_tim_shared | input | 3*CNT_W | Shared command timing word |
| cmd_tim_drv | input | NUM_DRV*3*CNT_W | Command timing word for each drive |
| dat_tim_drv | input | NUM_DRV*3*CNT_W | Data timing word for each drive |
| rst_ctl | input | 1 | Software drive-reset control, 1 = hold drive in reset |
| ide_rst_n | output | 1 | Drive reset, active low |
| ide_addr | output | ADDR_W | Device register address |
| ide_cs_n | output | 1 | Chip select, active low |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | DATA_W | Data bus out |
| ide_dd_oe | output | 1 | Data bus output enable |
| ide_dd_in | input | DATA_W | Data bus in |
| ide_iordy | input | 1 | Device ready |

## Verification
The hardest situations to reach are a ready line that is low exactly at the sample point, and one that drops just after it. The synchronizer delays the pin by two clocks, so the timing has to be arranged from the pins. For the stretch case, the bench lowers ready before the request is issued and raises it a fixed number of clocks later. For the late-drop case, it waits until it sees the strobe fall, then lowers ready one clock later, so the low value reaches the sampler only after the sample point. A behavioural model with its own ready history predicts every pin on every clock in both cases.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } pio_phase_e;

    localparam int FLD_SETUP = 0;
    localparam int FLD_ACT   = 1;
    localparam int FLD_REC   = 2;
    localparam int NUM_FLD   = 3;

endpackage

// File: rtl/ide_pio_rdy_sync.sv
module ide_pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ide_pio_tim_sel.sv
module ide_pio_tim_sel
    import ide_pio_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int NUM_DRV = 2,
    parameter int DRV_W   = 1,
    localparam int TIM_W  = NUM_FLD * CNT_W
) (
    input  logic [DRV_W-1:0]         drive,
    input  logic                     is_cmd,
    input  logic                     fmt_sel,
    input  logic [TIM_W-1:0]         cmd_shared,
    input  logic [NUM_DRV*TIM_W-1:0] cmd_drv,
    input  logic [NUM_DRV*TIM_W-1:0] dat_drv,
    output logic [NUM_FLD-1:0][CNT_W-1:0] len
);
    logic [TIM_W-1:0] word;

    always_comb begin
        if (!is_cmd)
            word = dat_drv[drive*TIM_W +: TIM_W];
        else if (fmt_sel)
            word = cmd_drv[drive*TIM_W +: TIM_W];
        else
            word = cmd_shared;
    end

    generate
        for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
            logic [CNT_W-1:0] raw;
            assign raw    = word[f*CNT_W +: CNT_W];
            assign len[f] = (raw == '0) ? CNT_W'(1) : raw;
        end
    endgenerate
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 4,
    parameter int NUM_DRV   = 2,
    parameter int SAMPLE_PT = 2,
    parameter int SYNC_STG  = 2,
    localparam int TIM_W    = NUM_FLD * CNT_W,
    localparam int DRV_W    = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
    localparam int EL_W     = $clog2(SAMPLE_PT + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [DRV_W-1:0]         req_drive,
    input  logic                     req_write,
    input  logic                     req_cmd,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     fmt_sel,
    input  logic [TIM_W-1:0]         cmd_tim_shared,
    input  logic [NUM_DRV*TIM_W-1:0] cmd_tim_drv,
    input  logic [NUM_DRV*TIM_W-1:0] dat_tim_drv,
    input  logic                     rst_ctl,
    output logic                     ide_rst_n,
    output logic [ADDR_W-1:0]        ide_addr,
    output logic                     ide_cs_n,
    output logic                     ide_dior_n,
    output logic                     ide_diow_n,
    output logic [DATA_W-1:0]        ide_dd_out,
    output logic                     ide_dd_oe,
    input  logic [DATA_W-1:0]        ide_dd_in,
    input  logic                     ide_iordy
);
    localparam logic [EL_W-1:0] SP_V = EL_W'(SAMPLE_PT);

    typedef struct packed {
        pio_phase_e         ph;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   act_m1;
        logic [CNT_W-1:0]   rec_m1;
        logic [EL_W-1:0]    el;
        logic               sampled;
        logic               stall;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               done;
        logic               cs_n;
        logic               dior_n;
        logic               diow_n;
        logic               oe;
    } seq_t;

    seq_t q, d;

    logic rdy_s;
    logic [NUM_FLD-1:0][CNT_W-1:0] sel_len;
    logic rst_out_q;

    ide_pio_rdy_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ide_iordy),
        .sync_out (rdy_s)
    );

    ide_pio_tim_sel #(.CNT_W(CNT_W), .NUM_DRV(NUM_DRV), .DRV_W(DRV_W)) u_sel (
        .drive      (req_drive),
        .is_cmd     (req_cmd),
        .fmt_sel    (fmt_sel),
        .cmd_shared (cmd_tim_shared),
        .cmd_drv    (cmd_tim_drv),
        .dat_drv    (dat_tim_drv),
        .len        (sel_len)
    );

    logic sample_now;
    logic hold;

    always_comb begin
        d      = q;
        d.done = 1'b0;

        sample_now = (q.ph == PH_ACTIVE) && !q.sampled &&
                     ((q.el == SP_V) || (q.cnt == '0));
        hold       = q.stall ? !rdy_s : (sample_now && !rdy_s);

        unique case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    d.ph     = PH_SETUP;
                    d.cnt    = sel_len[FLD_SETUP] - 1'b1;
                    d.act_m1 = sel_len[FLD_ACT] - 1'b1;
                    d.rec_m1 = sel_len[FLD_REC] - 1'b1;
                    d.wr     = req_write;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph      = PH_ACTIVE;
                    d.cnt     = q.act_m1;
                    d.el      = '0;
                    d.sampled = 1'b0;
                    d.stall   = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_ACTIVE: begin
                if (q.el < SP_V)
                    d.el = q.el + 1'b1;
                if (sample_now) begin
                    d.sampled = 1'b1;
                    d.stall   = !rdy_s;
                end else if (q.stall && rdy_s) begin
                    d.stall = 1'b0;
                end
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!hold) begin
                    d.ph  = PH_RECOV;
                    d.cnt = q.rec_m1;
                    if (!q.wr)
                        d.rdata = ide_dd_in;
                end
            end
            PH_RECOV: begin
                if (q.cnt == '0) begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        d.cs_n   = (d.ph == PH_IDLE);
        d.dior_n = !((d.ph == PH_ACTIVE) && !d.wr);
        d.diow_n = !((d.ph == PH_ACTIVE) && d.wr);
        d.oe     = (d.ph != PH_IDLE) && d.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ph     <= PH_IDLE;
            q.cs_n   <= 1'b1;
            q.dior_n <= 1'b1;
            q.diow_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Drive reset follows software only; the block reset does not touch it.
    always_ff @(posedge clk) begin
        rst_out_q <= !rst_ctl;
    end

    assign busy       = (q.ph != PH_IDLE);
    assign done       = q.done;
    assign rdata      = q.rdata;
    assign ide_addr   = q.addr;
    assign ide_cs_n   = q.cs_n;
    assign ide_dior_n = q.dior_n;
    assign ide_diow_n = q.diow_n;
    assign ide_dd_out = q.wdata;
    assign ide_dd_oe  = q.oe;
    assign ide_rst_n  = rst_out_q;
endmodule

// File: rtl/ide_pio_seq_chk.sv
module ide_pio_seq_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rst_ctl,
    input logic              ide_rst_n,
    input logic [ADDR_W-1:0] ide_addr,
    input logic              ide_cs_n,
    input logic              ide_dior_n,
    input logic              ide_diow_n,
    input logic [DATA_W-1:0] ide_dd_out,
    input logic              ide_dd_oe
);
    // R1: a strobe is only ever asserted under chip select
    a_r1_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_dior_n || !ide_diow_n) |-> !ide_cs_n);

    // R1: read and write strobes are never low together
    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_dior_n && !ide_diow_n));

    // R1: address holds steady across a transfer
    a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ide_addr));

    // R9: done lasts a single clock and follows a busy clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: data bus driven only during a transfer, with steady data
    a_r8_oe_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        ide_dd_oe |-> !ide_cs_n);
    a_r8_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_dd_oe && $past(ide_dd_oe)) |-> $stable(ide_dd_out));

    // R11: drive reset follows the software bit one clock later
    a_r11_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ide_rst_n == !$past(rst_ctl));
endmodule

bind ide_pio_seq ide_pio_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .rst_ctl    (rst_ctl),
    .ide_rst_n  (ide_rst_n),
    .ide_addr   (ide_addr),
    .ide_cs_n   (ide_cs_n),
    .ide_dior_n (ide_dior_n),
    .ide_diow_n (ide_diow_n),
    .ide_dd_out (ide_dd_out),
    .ide_dd_oe  (ide_dd_oe)
);

// File: tb/ide_pio_seq_bench.sv
`timescale 1ns/1ps
module ide_pio_seq_bench;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;
    localparam int TIM_W  = 3 * CNT_W;
    localparam int SP     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [0:0] req_drive = '0;
    logic req_write = 1'b0;
    logic req_cmd = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic busy, done;
    logic [DATA_W-1:0] rdata;
    logic fmt_sel = 1'b0;
    logic [TIM_W-1:0] cmd_tim_shared;
    logic [2*TIM_W-1:0] cmd_tim_drv, dat_tim_drv;
    logic rst_ctl = 1'b0;
    logic ide_rst_n;
    logic [ADDR_W-1:0] ide_addr;
    logic ide_cs_n, ide_dior_n, ide_diow_n, ide_dd_oe;
    logic [DATA_W-1:0] ide_dd_out;
    logic [DATA_W-1:0] ide_dd_in = '0;
    logic ide_iordy = 1'b1;

    always #2.5 clk = ~clk;

    ide_pio_seq u_ide_pio_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .fmt_sel(fmt_sel), .cmd_tim_shared(cmd_tim_shared),
        .cmd_tim_drv(cmd_tim_drv), .dat_tim_drv(dat_tim_drv),
        .rst_ctl(rst_ctl), .ide_rst_n(ide_rst_n), .ide_addr(ide_addr),
        .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
        .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe), .ide_dd_in(ide_dd_in),
        .ide_iordy(ide_iordy)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [TIM_W-1:0] tw(input int s, input int a, input int r);
        return {CNT_W'(r), CNT_W'(a), CNT_W'(s)};
    endfunction

    function automatic int eff(input logic [CNT_W-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // ---------------- behavioural reference model ----------------
    int  m_ph = 0;          // 0 idle, 1 setup, 2 active, 3 recovery
    int  m_left, m_a, m_r, m_el;
    bit  m_samp, m_stall, m_done, m_wr;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wd, m_rd;
    bit  h1, h2;
    bit  rst_seen = 0;
    bit  m_rstout;
    int  strobe_len = 0, last_strobe = 0, done_cnt = 0;

    always @(negedge clk) begin
        if (rst_seen)
            chk(ide_rst_n == m_rstout, "R11 drive reset", ide_rst_n, m_rstout);
        m_rstout = !rst_ctl;
        rst_seen = 1;

        if (!rst_n) begin
            m_ph = 0; m_done = 0; m_rd = '0; h1 = 0; h2 = 0;
        end else begin
            logic [TIM_W-1:0] w;
            bit rs, sn, hold;
            chk(busy == (m_ph != 0), "R9 busy", busy, m_ph != 0);
            chk(done == m_done, "R9 done", done, m_done);
            chk(ide_cs_n == (m_ph == 0), "R1 cs_n", ide_cs_n, m_ph == 0);
            chk(ide_dior_n == !(m_ph == 2 && !m_wr), "R1 dior_n", ide_dior_n, !(m_ph == 2 && !m_wr));
            chk(ide_diow_n == !(m_ph == 2 && m_wr), "R1 diow_n", ide_diow_n, !(m_ph == 2 && m_wr));
            chk(ide_dd_oe == (m_ph != 0 && m_wr), "R8 dd_oe", ide_dd_oe, m_ph != 0 && m_wr);
            if (m_ph != 0) chk(ide_addr == m_addr, "R1 addr", ide_addr, m_addr);
            if (m_ph != 0 && m_wr) chk(ide_dd_out == m_wd, "R8 dd_out", ide_dd_out, m_wd);
            if (m_done && !m_wr) chk(rdata == m_rd, "R8 rdata", rdata, m_rd);

            if (!ide_dior_n || !ide_diow_n) strobe_len++;
            else if (strobe_len != 0) begin last_strobe = strobe_len; strobe_len = 0; end
            if (done) done_cnt++;

            rs = h2;
            m_done = 0;
            case (m_ph)
                0: if (req_valid) begin
                    if (!req_cmd)     w = dat_tim_drv[req_drive*TIM_W +: TIM_W];
                    else if (fmt_sel) w = cmd_tim_drv[req_drive*TIM_W +: TIM_W];
                    else              w = cmd_tim_shared;
                    m_ph = 1; m_left = eff(w[CNT_W-1:0]);
                    m_a = eff(w[2*CNT_W-1:CNT_W]); m_r = eff(w[3*CNT_W-1:2*CNT_W]);
                    m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
                end
                1: if (m_left == 1) begin
                    m_ph = 2; m_left = m_a; m_el = 0; m_samp = 0; m_stall = 0;
                end else m_left--;
                2: begin
                    sn   = !m_samp && (m_el == SP || m_left == 1);
                    hold = m_stall ? !rs : (sn && !rs);
                    if (sn) begin m_samp = 1; m_stall = !rs; end
                    else if (m_stall && rs) m_stall = 0;
                    if (m_el < SP) m_el++;
                    if (m_left > 1) m_left--;
                    else if (!hold) begin
                        m_ph = 3; m_left = m_r;
                        if (!m_wr) m_rd = ide_dd_in;
                    end
                end
                default: if (m_left == 1) begin m_ph = 0; m_done = 1; end
                         else m_left--;
            endcase
            h2 = h1; h1 = ide_iordy;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit drv, input bit wr, input bit cmd,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
        @(posedge clk); #1;
        req_valid = 1; req_drive = drv; req_write = wr; req_cmd = cmd;
        req_addr = a; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 0;
        do @(negedge clk); while (!done);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cmd_tim_shared = tw(3, 4, 3);
        cmd_tim_drv    = {tw(4, 5, 1), tw(2, 3, 2)};
        dat_tim_drv    = {tw(2, 6, 3), tw(1, 2, 1)};
        repeat (4) @(negedge clk);
        // R11: drive reset stays released while the block reset is held
        chk(ide_rst_n == 1'b1, "R11 not forced by reset", ide_rst_n, 1);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(ide_cs_n == 1 && ide_dior_n == 1 && ide_diow_n == 1 && busy == 0,
            "R9 reset state", {ide_cs_n, ide_dior_n, ide_diow_n, busy}, 4'b1110);

        // R3: data read, drive 0 (1/2/1)
        ide_dd_in = 16'hA5C3;
        issue(0, 0, 0, 3'd0, '0);
        chk(last_strobe == 2, "R3 drive0 data strobe", last_strobe, 2);
        chk(rdata == 16'hA5C3, "R8 read capture", rdata, 16'hA5C3);
        // R3: data write, drive 1 (2/6/3)
        issue(1, 1, 0, 3'd0, 16'h1234);
        chk(last_strobe == 6, "R3 drive1 data strobe", last_strobe, 6);
        // R4: command, format 0 -> shared (3/4/3)
        ide_dd_in = 16'h0050;
        issue(1, 0, 1, 3'd7, '0);
        chk(last_strobe == 4, "R4 shared command strobe", last_strobe, 4);
        // R4: command, format 1 -> per drive
        fmt_sel = 1;
        issue(0, 1, 1, 3'd6, 16'h00EC);
        chk(last_strobe == 3, "R4 drive0 command strobe", last_strobe, 3);
        issue(1, 0, 1, 3'd1, '0);
        chk(last_strobe == 5, "R4 drive1 command strobe", last_strobe, 5);
        // R2: zero fields give one clock per phase
        dat_tim_drv[TIM_W-1:0] = '0;
        issue(0, 1, 0, 3'd2, 16'hBEEF);
        chk(last_strobe == 1, "R2 zero field minimum", last_strobe, 1);
        dat_tim_drv[TIM_W-1:0] = tw(1, 2, 1);

        // R5/R6: ready low at sample point stretches strobe
        @(posedge clk); #1 ide_iordy = 0;
        fork
            issue(1, 0, 0, 3'd0, '0);
            begin repeat (14) @(posedge clk); #1 ide_iordy = 1; end
        join
        chk(last_strobe > 6, "R6 stretched strobe", last_strobe, 7);
        // R5: ready high at sample point keeps nominal length
        issue(1, 0, 0, 3'd0, '0);
        chk(last_strobe == 6, "R5 nominal strobe", last_strobe, 6);
        // R7: ready drop after sample point is ignored
        fork
            issue(1, 0, 0, 3'd3, '0);
            begin
                do @(negedge clk); while (ide_dior_n);
                @(posedge clk); #1 ide_iordy = 0;
                do @(negedge clk); while (!done);
                #1 ide_iordy = 1;
            end
        join
        chk(last_strobe == 6, "R7 late drop ignored", last_strobe, 6);

        // R10: request pulse during busy is ignored
        done_cnt = 0;
        fork
            issue(1, 1, 0, 3'd4, 16'h5555);
            begin repeat (4) @(posedge clk); #1 req_valid = 1; req_addr = 3'd5;
                  @(posedge clk); #1 req_valid = 0; end
        join
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R10 single transfer", done_cnt, 1);

        // R9/R10: back-to-back with request held through done
        done_cnt = 0;
        @(posedge clk); #1 req_valid = 1; req_drive = 0; req_write = 0; req_cmd = 0;
        do @(negedge clk); while (!done);
        @(posedge clk); #1 req_valid = 0;
        do @(negedge clk); while (!done);
        repeat (3) @(negedge clk);
        chk(done_cnt == 2, "R9 back-to-back count", done_cnt, 2);

        // R11: software drive reset
        @(posedge clk); #1 rst_ctl = 1;
        repeat (2) @(negedge clk);
        chk(ide_rst_n == 0, "R11 asserted", ide_rst_n, 0);
        @(posedge clk); #1 rst_ctl = 0;
        repeat (2) @(negedge clk);
        chk(ide_rst_n == 1, "R11 released", ide_rst_n, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule